// File: doc/BRIEF.md
# Bidirectional Strobed Bus Port

This block is one 8-bit peripheral port that sends and receives over the same set of pins. A host writes a byte into an output latch and reads a byte from a separate input latch. A peripheral pushes data in with an active-low strobe and takes data out with an active-low acknowledge. Both handshakes run at the same time and are independent of each other. They share one interrupt request line.

The pins are presented as a data-in bus, a data-out bus and a single output enable. The enable is high only while the peripheral holds acknowledge low. At all other times the pins should be left high-impedance by the pad that the enable controls.

Each direction has its own interrupt enable. They are set and cleared by bit set/reset commands aimed at port-C bit positions 4 (input) and 6 (output). All strobes are sampled on the rising edge of `clk`, and edges are detected between two consecutive samples.

Top module: `bsp_port`

## Requirements
- R1: While `rst` is high and after it falls, `ibf` is 0, `obf_n` is 1, both interrupt enables are 0, `intr` is 0 and `bus_rdata` is 0.
- R2: A clock edge that samples `stb_n` low loads `pin_in` into the input latch and sets `ibf`. Both are visible after that edge, and `bus_rdata` always shows the input latch.
- R3: `ibf` clears on the edge that sees `bus_rd_n` high after a sample with it low (end of a read). If `stb_n` is low on that same edge, the strobe wins and `ibf` stays set.
- R4: On the edge that sees `bus_wr_n` low after a sample with it high (start of a write), `bus_wdata` is loaded into the output latch and `obf_n` goes low. Holding `bus_wr_n` low for more cycles does not reload the latch.
- R5: An edge that samples `ack_n` low sets `obf_n` high, unless a write start falls on that same edge, in which case the write wins.
- R6: `pin_oe` is 1 exactly while `ack_n` is 0, and whenever it is 1, `pin_out` carries the output latch. The pins are never driven while `stb_n` is low.
- R7: When `ctl_wr` is 1, `ctl_val` is written to the input enable if `ctl_bit` is 4, or to the output enable if `ctl_bit` is 6. Any other `ctl_bit` value changes neither enable.
- R8: `intr` equals (`ibf` AND `stb_n` AND input enable) OR (`obf_n` AND `ack_n` AND output enable), evaluated on the current state and inputs.
- R9: Input-side activity (strobe, read) never changes `obf_n` or the output latch. Output-side activity (write, acknowledge) never changes `ibf` or the input latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Input latch contents |
| ctl_wr | input | 1 | Bit set/reset command valid |
| ctl_bit | input | 3 | Target bit position of the command |
| ctl_val | input | 1 | Value written by the command |
| pin_in | input | 8 | Data arriving on the port pins |
| pin_out | output | 8 | Data to drive on the port pins |
| pin_oe | output | 1 | Pin driver enable |
| stb_n | input | 1 | Peripheral strobe, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| ibf | output | 1 | Input buffer full |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Merged interrupt request |

## Verification
The assertions take for granted that the peripheral never pulls strobe and acknowledge low in the same cycle. If it did, it would be loading the pins while the port drives them, and the no-drive check would fire. They also assume that every input is known and changes only between clock edges. The stimulus respects both assumptions. It changes inputs only on the falling clock edge, and whenever it draws a low strobe it forces acknowledge high, while read, write and enable commands still land in any combination, including the same-cycle collisions.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

   // Per-direction interrupt enables
   typedef struct packed {
      logic in_en;
      logic out_en;
   } bsp_ena_t;

   // Merged request: input side pending or output side free
   function automatic logic bsp_irq(input logic full, input logic stb_n,
                                    input logic empty, input logic ack_n,
                                    input bsp_ena_t e);
      return (full & stb_n & e.in_en) | (empty & ack_n & e.out_en);
   endfunction

endpackage

// File: rtl/bsp_edge.sv
module bsp_edge #(
   parameter bit RISE = 1'b1,
   parameter bit IDLE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic sig,
   output logic ev
);
   logic q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) q <= IDLE;
      else     q <= sig;
   end

   generate
      if (RISE) begin : g_rise
         assign ev = sig & ~q;
      end else begin : g_fall
         assign ev = ~sig & q;
      end
   endgenerate
endmodule

// File: rtl/bsp_rx.sv
module bsp_rx #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          stb_n,
   input  logic          rd_rise,
   input  logic [DW-1:0] pin_in,
   output logic          full,
   output logic [DW-1:0] data
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         full <= 1'b0;
         data <= '0;
      end else if (!stb_n) begin
         full <= 1'b1;
         data <= pin_in;
      end else if (rd_rise) begin
         full <= 1'b0;
      end
   end

   assert_stb_load_R2: assert property (@(posedge clk) disable iff (rst)
      !stb_n |=> (full && data == $past(pin_in)));

   assert_rd_clear_R3: assert property (@(posedge clk) disable iff (rst)
      (stb_n && rd_rise) |=> !full);

   assert_rx_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (stb_n && !rd_rise) |=> ($stable(full) && $stable(data)));
endmodule

// File: rtl/bsp_tx.sv
module bsp_tx #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_fall,
   input  logic          ack_n,
   input  logic [DW-1:0] wdata,
   output logic          obf_n,
   output logic [DW-1:0] data,
   output logic          oe
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         obf_n <= 1'b1;
         data  <= '0;
      end else if (wr_fall) begin
         obf_n <= 1'b0;
         data  <= wdata;
      end else if (!ack_n) begin
         obf_n <= 1'b1;
      end
   end

   assign oe = ~ack_n;

   assert_wr_load_R4: assert property (@(posedge clk) disable iff (rst)
      wr_fall |=> (!obf_n && data == $past(wdata)));

   assert_ack_free_R5: assert property (@(posedge clk) disable iff (rst)
      (!ack_n && !wr_fall) |=> obf_n);

   assert_tx_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !wr_fall |=> $stable(data));
endmodule

// File: rtl/bsp_port.sv
module bsp_port #(
   parameter int DW      = 8,
   parameter int IEN_BIT = 4,
   parameter int OEN_BIT = 6,
   localparam int CBW    = $clog2(DW)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           bus_rd_n,
   input  logic           bus_wr_n,
   input  logic [DW-1:0]  bus_wdata,
   output logic [DW-1:0]  bus_rdata,
   input  logic           ctl_wr,
   input  logic [CBW-1:0] ctl_bit,
   input  logic           ctl_val,
   input  logic [DW-1:0]  pin_in,
   output logic [DW-1:0]  pin_out,
   output logic           pin_oe,
   input  logic           stb_n,
   input  logic           ack_n,
   output logic           ibf,
   output logic           obf_n,
   output logic           intr
);
   import bsp_pkg::*;

   generate
      if (IEN_BIT == OEN_BIT) begin : g_bad_idx
         $error("enable bit positions must differ");
      end
      if (IEN_BIT >= DW || OEN_BIT >= DW || IEN_BIT < 0 || OEN_BIT < 0) begin : g_bad_range
         $error("enable bit position outside port width");
      end
      if (DW < 2) begin : g_bad_dw
         $error("port width too small");
      end
   endgenerate

   logic     rd_rise;
   logic     wr_fall;
   bsp_ena_t ena;

   bsp_edge #(.RISE(1'b1), .IDLE(1'b1)) u_rd_edge (
      .clk(clk), .rst(rst), .sig(bus_rd_n), .ev(rd_rise));

   bsp_edge #(.RISE(1'b0), .IDLE(1'b1)) u_wr_edge (
      .clk(clk), .rst(rst), .sig(bus_wr_n), .ev(wr_fall));

   bsp_rx #(.DW(DW)) u_rx (
      .clk(clk), .rst(rst), .stb_n(stb_n), .rd_rise(rd_rise),
      .pin_in(pin_in), .full(ibf), .data(bus_rdata));

   bsp_tx #(.DW(DW)) u_tx (
      .clk(clk), .rst(rst), .wr_fall(wr_fall), .ack_n(ack_n),
      .wdata(bus_wdata), .obf_n(obf_n), .data(pin_out), .oe(pin_oe));

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         ena <= '0;
      end else if (ctl_wr) begin
         if (ctl_bit == CBW'(IEN_BIT)) ena.in_en  <= ctl_val;
         if (ctl_bit == CBW'(OEN_BIT)) ena.out_en <= ctl_val;
      end
   end

   assign intr = bsp_irq(ibf, stb_n, obf_n, ack_n, ena);

   assert_ctl_ignore_R7: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && ctl_bit != CBW'(IEN_BIT) && ctl_bit != CBW'(OEN_BIT)) |=> $stable(ena));

   assert_intr_gate_R8: assert property (@(posedge clk) disable iff (rst)
      intr |-> ((ena.in_en && ibf && stb_n) || (ena.out_en && obf_n && !pin_oe)));

   assert_no_drive_on_strobe_R6: assert property (@(posedge clk) disable iff (rst)
      !stb_n |-> !pin_oe);
endmodule

// File: tb/sim_bsp_port.sv
`timescale 1ns/1ps
module sim_bsp_port;
   logic       clk = 1'b0;
   logic       rst;
   logic       bus_rd_n, bus_wr_n;
   logic [7:0] bus_wdata, bus_rdata;
   logic       ctl_wr;
   logic [2:0] ctl_bit;
   logic       ctl_val;
   logic [7:0] pin_in, pin_out;
   logic       pin_oe, stb_n, ack_n, ibf, obf_n, intr;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // bench model state
   bit       m_ibf, m_obfn, m_ien, m_oen, m_prd, m_pwr;
   bit [7:0] m_in, m_out;

   always #2 clk = ~clk;

   bsp_port u0 (
      .clk(clk), .rst(rst), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_wr(ctl_wr),
      .ctl_bit(ctl_bit), .ctl_val(ctl_val), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .stb_n(stb_n), .ack_n(ack_n),
      .ibf(ibf), .obf_n(obf_n), .intr(intr));

   task automatic chk(input bit ok, input string req, input string tag,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s [%s] actual=%0h expected=%0h", req, tag, act, exp);
      end
   endtask

   function automatic bit exp_intr();
      return (m_ibf & stb_n & m_ien) | (m_obfn & ack_n & m_oen);
   endfunction

   task automatic compare(input string tag);
      chk(ibf == m_ibf, "R2/R3 ibf", tag, ibf, m_ibf);
      chk(obf_n == m_obfn, "R4/R5 obf_n", tag, obf_n, m_obfn);
      chk(bus_rdata == m_in, "R2 rdata", tag, bus_rdata, m_in);
      chk(pin_oe == !ack_n, "R6 oe", tag, pin_oe, !ack_n);
      if (pin_oe) chk(pin_out == m_out, "R4/R6 pin_out", tag, pin_out, m_out);
      chk(intr == exp_intr(), "R8 intr", tag, intr, exp_intr());
      if (!stb_n) chk(!pin_oe, "R6 no drive on strobe", tag, pin_oe, 0);
   endtask

   // One cycle: drive at falling edge, check, then advance model at rising edge
   task automatic cyc(input bit s, input bit a, input bit rd, input bit wr,
                      input bit [7:0] wd, input bit [7:0] pi,
                      input bit cw, input bit [2:0] cb, input bit cv,
                      input string tag);
      bit rr, wf;
      @(negedge clk);
      stb_n = s; ack_n = a; bus_rd_n = rd; bus_wr_n = wr;
      bus_wdata = wd; pin_in = pi; ctl_wr = cw; ctl_bit = cb; ctl_val = cv;
      #1;
      compare(tag);
      @(posedge clk);
      rr = rd & !m_prd;
      wf = !wr & m_pwr;
      if (!s) begin m_ibf = 1'b1; m_in = pi; end
      else if (rr) m_ibf = 1'b0;
      if (wf) begin m_obfn = 1'b0; m_out = wd; end
      else if (!a) m_obfn = 1'b1;
      if (cw && cb == 3'd4) m_ien = cv;
      if (cw && cb == 3'd6) m_oen = cv;
      m_prd = rd;
      m_pwr = wr;
   endtask

   task automatic idle(input string tag);
      cyc(1, 1, 1, 1, 8'h00, 8'h00, 0, 3'd0, 0, tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      int seed;
      seed = $urandom(32'h00c0ffee);
      rst = 1'b1; stb_n = 1; ack_n = 1; bus_rd_n = 1; bus_wr_n = 1;
      bus_wdata = 0; pin_in = 0; ctl_wr = 0; ctl_bit = 0; ctl_val = 0;
      m_ibf = 0; m_obfn = 1; m_ien = 0; m_oen = 0; m_prd = 1; m_pwr = 1;
      m_in = 0; m_out = 0;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(ibf == 0, "R1 ibf", "reset", ibf, 0);
      chk(obf_n == 1, "R1 obf_n", "reset", obf_n, 1);
      chk(intr == 0, "R1 intr", "reset", intr, 0);
      chk(bus_rdata == 0, "R1 rdata", "reset", bus_rdata, 0);
      chk(pin_oe == 0, "R1 oe", "reset", pin_oe, 0);
      @(negedge clk); rst = 1'b0;
      idle("R1 after reset");

      // R2: strobe capture, with input enable off
      cyc(0, 1, 1, 1, 8'h00, 8'hA5, 0, 3'd0, 0, "R2 strobe");
      idle("R2 after strobe");
      // R7: enable input side, then try an unrelated bit
      cyc(1, 1, 1, 1, 8'h00, 8'h00, 1, 3'd4, 1, "R7 set in_en");
      cyc(1, 1, 1, 1, 8'h00, 8'h00, 1, 3'd5, 0, "R7 bit5 ignored");
      cyc(1, 1, 1, 1, 8'h00, 8'h00, 1, 3'd7, 1, "R7 bit7 ignored");
      idle("R8 intr from input");
      // R3: read pulse clears ibf at its end
      cyc(1, 1, 0, 1, 8'h00, 8'h00, 0, 3'd0, 0, "R3 read low");
      cyc(1, 1, 1, 1, 8'h00, 8'h00, 0, 3'd0, 0, "R3 read end");
      idle("R3 cleared");
      // R3: strobe on the same edge as read end wins
      cyc(0, 1, 1, 1, 8'h00, 8'h3C, 0, 3'd0, 0, "R3 refill");
      cyc(1, 1, 0, 1, 8'h00, 8'h00, 0, 3'd0, 0, "R3 read low");
      cyc(0, 1, 1, 1, 8'h00, 8'h5A, 0, 3'd0, 0, "R3 strobe wins");
      idle("R3 still full");
      // R4: write held low for several cycles loads once
      cyc(1, 1, 1, 0, 8'h11, 8'h00, 1, 3'd6, 1, "R4 write start");
      cyc(1, 1, 1, 0, 8'h22, 8'h00, 0, 3'd0, 0, "R4 held");
      cyc(1, 1, 1, 0, 8'h33, 8'h00, 0, 3'd0, 0, "R4 held");
      cyc(1, 1, 1, 1, 8'h44, 8'h00, 0, 3'd0, 0, "R4 release");
      // R6/R5: acknowledge drives pins and frees the buffer
      cyc(1, 0, 1, 1, 8'h00, 8'h00, 0, 3'd0, 0, "R6 ack drive");
      cyc(1, 0, 1, 1, 8'h00, 8'h00, 0, 3'd0, 0, "R5 freed");
      idle("R8 intr from output");
      // R5: write start and acknowledge on the same edge, write wins
      cyc(1, 0, 1, 0, 8'h96, 8'h00, 0, 3'd0, 0, "R5 write wins");
      cyc(1, 1, 1, 1, 8'h00, 8'h00, 0, 3'd0, 0, "R5 still full");
      // R9: input activity while output is full
      cyc(0, 1, 1, 1, 8'h00, 8'hE7, 0, 3'd0, 0, "R9 strobe");
      cyc(1, 1, 0, 1, 8'h00, 8'h00, 0, 3'd0, 0, "R9 read");
      cyc(1, 1, 1, 1, 8'h00, 8'h00, 0, 3'd0, 0, "R9 read end");
      cyc(1, 0, 1, 1, 8'h00, 8'h00, 1, 3'd6, 0, "R9 ack, out_en off");
      idle("R9 settle");

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         bit s, a, rd, wr, cw, cv;
         bit [2:0] cb;
         s  = ($urandom % 6) == 0;
         s  = !s;
         a  = s ? (($urandom % 5) != 0) : 1'b1;   // never strobe while ack low
         rd = ($urandom % 3) != 0;
         wr = ($urandom % 3) != 0;
         cw = ($urandom % 8) == 0;
         cb = ($urandom % 2) ? (($urandom % 2) ? 3'd4 : 3'd6) : 3'($urandom);
         cv = 1'($urandom);
         cyc(s, a, rd, wr, 8'($urandom), 8'($urandom), cw, cb, cv, "R9 random");
      end
      idle("end");

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule